// File: doc/BRIEF.md
# Second-Operand Shifter with Rotated Immediate

This block is the combinational second-operand stage placed in front of a 32-bit ALU. It produces one 32-bit operand and a shifter carry-out. The operand comes from one of two sources, picked by a select input. The first source is a register value that is shifted by an amount. That amount is either a 5-bit field carried in the instruction or the low byte of a second register. The second source is a 12-bit immediate field that packs an 8-bit constant and a 4-bit rotate count.

There are four shift kinds: logical left, logical right, arithmetic right and rotate right. A fifth, a single-bit rotate through the carry, is reached through one of the immediate-amount encodings. An amount of zero and amounts of 32 or more are handled differently for the two amount sources. The ALU uses the carry-out as the shifter carry for logical operations that set flags. Flag writeback is not part of this block.

Top module: `opsh_operand2`

## Requirements
- R1: When `use_imm` is 1, `opnd` is the zero-extended constant `imm_field[7:0]` rotated right by twice `imm_field[11:8]` (0 to 30 positions), whatever the register inputs are.
- R2: When `use_imm` is 1, `carry_out` equals `opnd[31]` if `imm_field[11:8]` is nonzero, and equals `carry_in` if it is zero.
- R3: `kind` encodes 00 as shift left, 01 as logical right, 10 as arithmetic right and 11 as rotate right. A shift left by an immediate amount n of 1 to 31 gives the value shifted left by n with carry equal to bit 32-n. With n = 0 the value and `carry_in` pass unchanged.
- R4: A logical right shift by an immediate n of 1 to 31 fills with zeros, and the carry is bit n-1. An immediate amount of 0 means 32 here, which gives 0 with carry equal to bit 31.
- R5: An arithmetic right shift by an immediate n of 1 to 31 fills with copies of bit 31, and the carry is bit n-1. An immediate amount of 0 means 32, which gives all bits equal to bit 31, with that bit as the carry.
- R6: A rotate right by an immediate n of 1 to 31 moves the bits shifted out at bit 0 into bit 31. The carry is bit n-1 of the input, which is also bit 31 of the result.
- R7: A rotate right with an immediate amount of 0 is a one-bit rotate through carry: `carry_in` enters bit 31, bits 31..1 move down one place, and input bit 0 becomes the carry.
- R8: When `amt_from_reg` is 1, the amount is the unsigned byte `amt_reg`. An amount of 0 passes the value and `carry_in` unchanged for every kind.
- R9: With a register amount, a left or logical right shift by exactly 32 gives 0, with carry equal to bit 0 (left) or bit 31 (right). A shift above 32 gives 0 with carry 0. A shift of 1 to 31 behaves as in R3 and R4.
- R10: With a register amount, an arithmetic right shift by 32 or more gives all bits equal to bit 31, with that bit as the carry. A shift of 1 to 31 behaves as in R5.
- R11: With a nonzero register amount, a rotate right turns the value by the amount modulo 32, and the carry is bit 31 of the result. A nonzero multiple of 32 leaves the value unchanged, and the carry is its bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| use_imm | input | 1 | 1 selects the rotated immediate, 0 selects the shifted register |
| imm_field | input | 12 | Rotate count in [11:8], constant in [7:0] |
| rm_val | input | 32 | Register value to shift |
| kind | input | 2 | Shift kind: 00 left, 01 logical right, 10 arithmetic right, 11 rotate right |
| amt_from_reg | input | 1 | 1 takes the amount from `amt_reg`, 0 from `amt_imm` |
| amt_imm | input | 5 | Instruction-encoded shift amount |
| amt_reg | input | 8 | Low byte of the amount register |
| carry_in | input | 1 | Current carry flag |
| opnd | output | 32 | Second operand for the ALU |
| carry_out | output | 1 | Shifter carry-out |

## Verification
The bench goes after the encodings where amount zero does not mean "no shift". If immediate logical or arithmetic right by 0 were treated as no shift, the value and carry would pass through instead of giving zero or a sign fill. A missing rotate-through-carry would return the value unrotated. Register amounts of exactly 32, above 32, and nonzero multiples of 32 for rotate are all tested: a design that truncated the byte to five bits would return the unshifted value there. Immediate constants whose rotation wraps across bit 0, and a zero rotate with the carry set, show any wrong direction of rotation or wrong carry source.

// File: rtl/opsh_pkg.sv
// Package: shared encodings for the second-operand shifter.
// Assumes: the 2-bit kind field comes straight from the instruction.
package opsh_pkg;
    localparam logic [1:0] KIND_LSL = 2'b00;
    localparam logic [1:0] KIND_LSR = 2'b01;
    localparam logic [1:0] KIND_ASR = 2'b10;
    localparam logic [1:0] KIND_ROR = 2'b11;

    // Normalised operation after the amount edge cases are resolved.
    typedef enum logic [2:0] {
        SOP_PASS = 3'd0,
        SOP_LSL  = 3'd1,
        SOP_LSR  = 3'd2,
        SOP_ASR  = 3'd3,
        SOP_ROR  = 3'd4,
        SOP_RRX  = 3'd5
    } sop_e;
endpackage

// File: rtl/opsh_amt_decode.sv
// Module: opsh_amt_decode
// Turns kind plus an immediate or register amount into a normalised
// operation and a bounded count. All the special meanings of zero and of
// amounts of 32 or more are resolved here, so the shifter core never sees them.
// Assumes: FULL = 2**AMT_W is the datapath width; CNT_W can hold FULL+1.
module opsh_amt_decode
    import opsh_pkg::*;
#(
    parameter int AMT_W   = 5,
    parameter int RBYTE_W = 8,
    parameter int CNT_W   = 6
) (
    input  logic               from_reg,
    input  logic [1:0]         kind,
    input  logic [AMT_W-1:0]   amt_imm,
    input  logic [RBYTE_W-1:0] amt_reg,
    output sop_e               op,
    output logic [CNT_W-1:0]   cnt
);
    localparam int FULL = 1 << AMT_W;

    // Resolve the amount edge cases into an operation and a count.
    always_comb begin
        op  = SOP_PASS;
        cnt = '0;
        if (from_reg) begin
            if (amt_reg != '0) begin
                unique case (kind)
                    KIND_LSL, KIND_LSR: begin
                        op  = (kind == KIND_LSL) ? SOP_LSL : SOP_LSR;
                        cnt = (int'(amt_reg) > FULL + 1) ? CNT_W'(FULL + 1)
                                                         : CNT_W'(amt_reg);
                    end
                    KIND_ASR: begin
                        op  = SOP_ASR;
                        cnt = (int'(amt_reg) > FULL) ? CNT_W'(FULL)
                                                     : CNT_W'(amt_reg);
                    end
                    default: begin
                        op  = SOP_ROR;
                        cnt = CNT_W'(amt_reg[AMT_W-1:0]);
                    end
                endcase
            end
        end else begin
            unique case (kind)
                KIND_LSL: begin
                    op  = (amt_imm == '0) ? SOP_PASS : SOP_LSL;
                    cnt = CNT_W'(amt_imm);
                end
                KIND_LSR, KIND_ASR: begin
                    op  = (kind == KIND_LSR) ? SOP_LSR : SOP_ASR;
                    cnt = (amt_imm == '0) ? CNT_W'(FULL) : CNT_W'(amt_imm);
                end
                default: begin
                    op  = (amt_imm == '0) ? SOP_RRX : SOP_ROR;
                    cnt = CNT_W'(amt_imm);
                end
            endcase
        end
    end
endmodule

// File: rtl/opsh_shift_core.sv
// Module: opsh_shift_core
// Performs one normalised shift on a register value and yields the carry.
// Assumes: LSL/LSR count <= XLEN+1, ASR count <= XLEN, ROR count < XLEN.
module opsh_shift_core
    import opsh_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int CNT_W = 6
) (
    input  sop_e             op,
    input  logic [CNT_W-1:0] cnt,
    input  logic [XLEN-1:0]  val,
    input  logic             cin,
    output logic [XLEN-1:0]  res,
    output logic             cout
);
    logic [XLEN:0]          wide_l;
    logic [XLEN:0]          wide_r;
    logic signed [XLEN:0]   wide_a;
    logic [XLEN-1:0]        rot_v;
    logic [CNT_W-1:0]       rot_back;

    // Extended shifts: the extra bit catches the last bit shifted out.
    always_comb begin
        wide_l   = {1'b0, val} << cnt;
        wide_r   = {val, 1'b0} >> cnt;
        wide_a   = $signed({val, 1'b0}) >>> cnt;
        rot_back = CNT_W'(XLEN) - cnt;
        rot_v    = (val >> cnt) | (val << rot_back);
    end

    // Pick the result and the carry for the requested operation.
    always_comb begin
        unique case (op)
            SOP_LSL: begin res = wide_l[XLEN-1:0]; cout = wide_l[XLEN]; end
            SOP_LSR: begin res = wide_r[XLEN:1];   cout = wide_r[0];    end
            SOP_ASR: begin res = wide_a[XLEN:1];   cout = wide_a[0];    end
            SOP_ROR: begin res = rot_v;            cout = rot_v[XLEN-1]; end
            SOP_RRX: begin res = {cin, val[XLEN-1:1]}; cout = val[0];   end
            default: begin res = val;              cout = cin;          end
        endcase
    end

    // Guards on the shifter outputs against its own inputs.
    always_comb begin
        if (op == SOP_ASR) begin
            a_r5_sign_kept: assert (res[XLEN-1] == val[XLEN-1]);
        end
        if (op == SOP_ROR) begin
            a_r6_bits_conserved: assert ($countones(res) == $countones(val));
        end
        if (op == SOP_RRX) begin
            a_r7_carry_loop_conserved:
                assert ($countones({cout, res}) == $countones({cin, val}));
        end
        if (op == SOP_LSL && cnt != '0) begin
            a_r3_low_bit_cleared: assert (res[0] == 1'b0);
        end
        if (op == SOP_LSR && int'(cnt) >= XLEN) begin
            a_r9_wide_right_zero: assert (res == '0);
        end
    end
endmodule

// File: rtl/opsh_rot_imm.sv
// Module: opsh_rot_imm
// Expands a packed immediate (constant + rotate count) into a full-width
// operand by rotating the zero-extended constant right by twice the count.
// Assumes: 2 * (2**ROT_W - 1) < XLEN.
module opsh_rot_imm #(
    parameter int XLEN  = 32,
    parameter int IMM_W = 8,
    parameter int ROT_W = 4
) (
    input  logic [IMM_W+ROT_W-1:0] field,
    input  logic                   cin,
    output logic [XLEN-1:0]        res,
    output logic                   cout
);
    localparam int SH_W = $clog2(XLEN) + 1;

    logic [IMM_W-1:0] konst;
    logic [ROT_W-1:0] rot;
    logic [XLEN-1:0]  ext;
    logic [SH_W-1:0]  sh;
    logic [SH_W-1:0]  sh_back;

    // Unpack, double the rotate count and rotate right.
    always_comb begin
        konst   = field[IMM_W-1:0];
        rot     = field[IMM_W+ROT_W-1:IMM_W];
        ext     = XLEN'(konst);
        sh      = SH_W'({rot, 1'b0});
        sh_back = SH_W'(XLEN) - sh;
        res     = (ext >> sh) | (ext << sh_back);
        cout    = (rot != '0) ? res[XLEN-1] : cin;
    end

    // Guards: rotation keeps the constant's bits; no rotation leaves it in place.
    always_comb begin
        a_r1_ones_kept: assert ($countones(res) == $countones(konst));
        if (rot == '0) begin
            a_r1_unrotated_in_place: assert (res == ext);
        end
    end
endmodule

// File: rtl/opsh_operand2.sv
// Module: opsh_operand2 (top)
// Second-operand stage: either a shifted register value or a rotated
// immediate, with the shifter carry-out. Purely combinational.
// Assumes: the caller supplies the current carry flag on carry_in.
module opsh_operand2
    import opsh_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int IMM_W   = 8,
    parameter int ROT_W   = 4,
    parameter int RBYTE_W = 8
) (
    input  logic                     use_imm,
    input  logic [IMM_W+ROT_W-1:0]   imm_field,
    input  logic [XLEN-1:0]          rm_val,
    input  logic [1:0]               kind,
    input  logic                     amt_from_reg,
    input  logic [$clog2(XLEN)-1:0]  amt_imm,
    input  logic [RBYTE_W-1:0]       amt_reg,
    input  logic                     carry_in,
    output logic [XLEN-1:0]          opnd,
    output logic                     carry_out
);
    localparam int AMT_W = $clog2(XLEN);
    localparam int CNT_W = $clog2(XLEN + 2);

    sop_e             sh_op;
    logic [CNT_W-1:0] sh_cnt;
    logic [XLEN-1:0]  sh_res;
    logic             sh_cout;
    logic [XLEN-1:0]  im_res;
    logic             im_cout;

    opsh_amt_decode #(
        .AMT_W(AMT_W), .RBYTE_W(RBYTE_W), .CNT_W(CNT_W)
    ) u_decode (
        .from_reg(amt_from_reg),
        .kind    (kind),
        .amt_imm (amt_imm),
        .amt_reg (amt_reg),
        .op      (sh_op),
        .cnt     (sh_cnt)
    );

    opsh_shift_core #(
        .XLEN(XLEN), .CNT_W(CNT_W)
    ) u_core (
        .op  (sh_op),
        .cnt (sh_cnt),
        .val (rm_val),
        .cin (carry_in),
        .res (sh_res),
        .cout(sh_cout)
    );

    opsh_rot_imm #(
        .XLEN(XLEN), .IMM_W(IMM_W), .ROT_W(ROT_W)
    ) u_rotimm (
        .field(imm_field),
        .cin  (carry_in),
        .res  (im_res),
        .cout (im_cout)
    );

    // Choose the operand source.
    always_comb begin
        opnd      = use_imm ? im_res  : sh_res;
        carry_out = use_imm ? im_cout : sh_cout;
    end
endmodule

// File: tb/opsh_operand2_tb.sv
// Scoreboard bench: the driver applies stimulus and queues the expected
// result; the monitor pops and compares on the falling edge.
module opsh_operand2_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 20000;

    logic        clk = 1'b0;
    logic        use_imm = 1'b0;
    logic [11:0] imm_field = '0;
    logic [31:0] rm_val = '0;
    logic [1:0]  kind = '0;
    logic        amt_from_reg = 1'b0;
    logic [4:0]  amt_imm = '0;
    logic [7:0]  amt_reg = '0;
    logic        carry_in = 1'b0;
    logic [31:0] opnd;
    logic        carry_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] res;
        logic        c;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    opsh_operand2 u_dut (
        .use_imm(use_imm), .imm_field(imm_field), .rm_val(rm_val),
        .kind(kind), .amt_from_reg(amt_from_reg), .amt_imm(amt_imm),
        .amt_reg(amt_reg), .carry_in(carry_in),
        .opnd(opnd), .carry_out(carry_out)
    );

    // Reference: immediate rotated one place at a time.
    function automatic logic [32:0] ref_imm(input logic [11:0] f, input logic c);
        logic [31:0] r;
        r = {24'b0, f[7:0]};
        for (int i = 0; i < 2 * int'(f[11:8]); i++) r = {r[0], r[31:1]};
        return {(f[11:8] != 4'd0) ? r[31] : c, r};
    endfunction

    // Reference: register shift done one bit per step.
    function automatic logic [32:0] ref_reg(input logic [31:0] v, input logic [1:0] k,
                                            input logic fr, input logic [4:0] ai,
                                            input logic [7:0] ar, input logic c);
        logic [31:0] r;
        logic cc;
        int n;
        bit rrx;
        r = v; cc = c; rrx = 1'b0;
        if (fr) n = int'(ar);
        else begin
            n = int'(ai);
            if (ai == 5'd0) begin
                if (k == 2'b01 || k == 2'b10) n = 32;
                if (k == 2'b11) rrx = 1'b1;
            end
        end
        if (rrx) begin
            cc = r[0];
            r = {c, r[31:1]};
        end else begin
            for (int i = 0; i < n; i++) begin
                case (k)
                    2'b00:   begin cc = r[31]; r = {r[30:0], 1'b0}; end
                    2'b01:   begin cc = r[0];  r = {1'b0, r[31:1]}; end
                    2'b10:   begin cc = r[0];  r = {r[31], r[31:1]}; end
                    default: begin cc = r[0];  r = {r[0], r[31:1]}; end
                endcase
            end
        end
        return {cc, r};
    endfunction

    // Driver: apply one vector and queue its expected result.
    task automatic drive(input logic ui, input logic [11:0] f, input logic [31:0] v,
                         input logic [1:0] k, input logic fr, input logic [4:0] ai,
                         input logic [7:0] ar, input logic c,
                         input logic [32:0] exp_v, input string tag);
        exp_t e;
        @(posedge clk);
        #1;
        use_imm = ui; imm_field = f; rm_val = v; kind = k;
        amt_from_reg = fr; amt_imm = ai; amt_reg = ar; carry_in = c;
        e.res = exp_v[31:0]; e.c = exp_v[32]; e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic imm_hand(input logic [11:0] f, input logic c, input logic [32:0] exp_v,
                            input string tag);
        // Register inputs set to noise: they must not matter.
        drive(1'b1, f, 32'hA5A5_5A5A, 2'b10, 1'b1, 5'd3, 8'd7, c, exp_v, tag);
    endtask

    task automatic reg_hand(input logic [31:0] v, input logic [1:0] k, input logic fr,
                            input logic [4:0] ai, input logic [7:0] ar, input logic c,
                            input logic [32:0] exp_v, input string tag);
        // Hand value and reference model must both agree.
        drive(1'b0, 12'hFFF, v, k, fr, ai, ar, c, exp_v, tag);
        drive(1'b0, 12'hFFF, v, k, fr, ai, ar, c, ref_reg(v, k, fr, ai, ar, c), tag);
    endtask

    // Monitor: compare the design output with the oldest expected item.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (opnd !== e.res || carry_out !== e.c) begin
                failures++;
                $display("FAIL %s: got opnd=%h carry=%b, expected opnd=%h carry=%b",
                         e.tag, opnd, carry_out, e.res, e.c);
            end
        end
    end

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // Idle state: all-zero inputs give zero operand and zero carry (R8).
        reg_hand(32'h0, 2'b00, 1'b1, 5'd0, 8'd0, 1'b0, 33'h0, "R8");
        // R1: hand-computed rotated constants.
        imm_hand(12'h8FF, 1'b0, {1'b0, 32'h00FF_0000}, "R1");
        imm_hand(12'hD40, 1'b0, {1'b0, 32'h0000_1000}, "R1");
        // R2: carry from bit 31 when rotating, held when not.
        imm_hand(12'h1FF, 1'b0, {1'b1, 32'hC000_003F}, "R2");
        imm_hand(12'h0AB, 1'b1, {1'b1, 32'h0000_00AB}, "R2");
        // R3
        reg_hand(32'h8000_0001, 2'b00, 1'b0, 5'd0, 8'd0, 1'b1, {1'b1, 32'h8000_0001}, "R3");
        reg_hand(32'hF000_0001, 2'b00, 1'b0, 5'd4, 8'd0, 1'b0, {1'b1, 32'h0000_0010}, "R3");
        // R4
        reg_hand(32'h8000_0000, 2'b01, 1'b0, 5'd0, 8'd0, 1'b0, {1'b1, 32'h0}, "R4");
        reg_hand(32'h0000_0003, 2'b01, 1'b0, 5'd1, 8'd0, 1'b0, {1'b1, 32'h1}, "R4");
        // R5
        reg_hand(32'h8000_0000, 2'b10, 1'b0, 5'd0, 8'd0, 1'b0, {1'b1, 32'hFFFF_FFFF}, "R5");
        reg_hand(32'h8000_0010, 2'b10, 1'b0, 5'd4, 8'd0, 1'b1, {1'b0, 32'hF800_0001}, "R5");
        // R6
        reg_hand(32'h1234_5678, 2'b11, 1'b0, 5'd8, 8'd0, 1'b1, {1'b0, 32'h7812_3456}, "R6");
        // R7
        reg_hand(32'h0000_0001, 2'b11, 1'b0, 5'd0, 8'd0, 1'b1, {1'b1, 32'h8000_0000}, "R7");
        reg_hand(32'h0000_0002, 2'b11, 1'b0, 5'd0, 8'd0, 1'b0, {1'b0, 32'h0000_0001}, "R7");
        // R8
        reg_hand(32'hDEAD_BEEF, 2'b01, 1'b1, 5'd9, 8'd0, 1'b1, {1'b1, 32'hDEAD_BEEF}, "R8");
        reg_hand(32'hDEAD_BEEF, 2'b11, 1'b1, 5'd0, 8'd0, 1'b0, {1'b0, 32'hDEAD_BEEF}, "R8");
        // R9
        reg_hand(32'h0000_0001, 2'b00, 1'b1, 5'd0, 8'd32, 1'b0, {1'b1, 32'h0}, "R9");
        reg_hand(32'h8000_0000, 2'b01, 1'b1, 5'd0, 8'd32, 1'b0, {1'b1, 32'h0}, "R9");
        reg_hand(32'hFFFF_FFFF, 2'b00, 1'b1, 5'd0, 8'd33, 1'b1, {1'b0, 32'h0}, "R9");
        reg_hand(32'hFFFF_FFFF, 2'b01, 1'b1, 5'd0, 8'd200, 1'b1, {1'b0, 32'h0}, "R9");
        // R10
        reg_hand(32'h8000_0000, 2'b10, 1'b1, 5'd0, 8'd40, 1'b0, {1'b1, 32'hFFFF_FFFF}, "R10");
        reg_hand(32'h7FFF_FFFF, 2'b10, 1'b1, 5'd0, 8'd255, 1'b1, {1'b0, 32'h0}, "R10");
        // R11
        reg_hand(32'h8000_0001, 2'b11, 1'b1, 5'd0, 8'd32, 1'b0, {1'b1, 32'h8000_0001}, "R11");
        reg_hand(32'h0000_00F0, 2'b11, 1'b1, 5'd0, 8'd36, 1'b1, {1'b0, 32'h0000_000F}, "R11");
        reg_hand(32'h0000_0001, 2'b11, 1'b1, 5'd0, 8'd64, 1'b1, {1'b0, 32'h0000_0001}, "R11");

        // Random sweep against the bit-step reference models.
        for (int i = 0; i < 600; i++) begin
            logic [31:0] v;
            logic [11:0] f;
            logic [1:0]  k;
            logic        fr, c;
            logic [4:0]  ai;
            logic [7:0]  ar;
            string       tag;
            v = $urandom; f = 12'($urandom); k = 2'($urandom);
            fr = 1'($urandom); c = 1'($urandom);
            ai = 5'($urandom); ar = 8'($urandom);
            if (i % 4 == 0) ar = 8'(28 + ($urandom % 10));
            if (i % 3 == 0) begin
                tag = (f[11:8] == 4'd0) ? "R2" : "R1";
                drive(1'b1, f, v, k, fr, ai, ar, c, ref_imm(f, c), tag);
            end else begin
                if (fr) tag = (ar == 8'd0) ? "R8" : (k == 2'b10) ? "R10" :
                              (k == 2'b11) ? "R11" : "R9";
                else    tag = (k == 2'b00) ? "R3" : (k == 2'b01) ? "R4" :
                              (k == 2'b10) ? "R5" : (ai == 5'd0) ? "R7" : "R6";
                drive(1'b0, f, v, k, fr, ai, ar, c, ref_reg(v, k, fr, ai, ar, c), tag);
            end
        end

        repeat (3) @(posedge clk);
        done = 1'b1;
        if (sb_q.size() != 0) begin
            failures++;
            $display("FAIL scoreboard: got %0d pending, expected 0", sb_q.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule